// File: doc/BRIEF.md
# UART Channel Loop Mode Router

This block sits between a UART transmitter core, a UART receiver core and the two serial pins. A two-bit mode field picks how serial data is routed: a normal path; automatic echo, where the line heard on RxD is sent back out on TxD one receiver bit at a time; local loopback, where the transmitter feeds the receiver internally; and remote loopback, where RxD is turned around to TxD and nothing reaches the receiver core.

In the modes that retransmit received data, the transmitter core's ready and empty flags are forced inactive, because the CPU-to-transmitter path is out of use. The echo path is a register clocked by the receiver bit tick, after a parameterised input synchronizer. It therefore sends parity and stop bits exactly as they arrived, with no regeneration. When the receiver flags a break, TxD is held at space until the receiver reports the next valid start bit. Mode changes act on the routing at once, even in the middle of a character.

Top module: `uart_loop_router`

## Requirements
- R1: In normal mode (mode = 2'b00), txd_pin equals tx_core_sd and rx_core_sd equals rxd_pin in the same cycle, and tx_rdy_flag / tx_emp_flag equal tx_rdy_raw / tx_emp_raw.
- R2: In echo mode (mode = 2'b01) with rx_enable high, txd_pin shows the echo register. On the clock edge where rx_tick is high, that register loads rxd_pin as it stood at least SYNC_STAGES+1 cycles earlier. It holds between ticks, so the value on txd_pin changes one cycle after the tick. tx_core_sd has no effect.
- R3: In echo mode with rx_enable low, txd_pin is held at mark (1). In echo mode the receiver path stays normal, so rx_core_sd equals rxd_pin.
- R4: In local loopback (mode = 2'b10), txd_pin is held at mark (1) and rx_core_sd equals tx_core_sd. rxd_pin has no effect on any output.
- R5: In echo and remote loopback modes, tx_rdy_flag and tx_emp_flag are 0 whatever the raw flags are. In local loopback they equal the raw flags.
- R6: In remote loopback (mode = 2'b11), txd_pin shows the echo register whatever rx_enable is, and rx_core_sd is held at mark (1).
- R7: In echo or remote mode, rx_break_det high at a clock edge forces txd_pin to space (0) from the next cycle. The hold lasts until an edge with rx_start_det high or a mode outside those two. Ticks taken during the hold do not release it.
- R8: A change on mode changes the routing of txd_pin, rx_core_sd and the status flags in the same cycle, with no clock edge needed.
- R9: After reset the echo register holds mark (1) and no break hold is pending, so echo mode drives txd_pin to 1 until the first tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Loop mode: 00 normal, 01 echo, 10 local, 11 remote |
| rx_enable | input | 1 | Receiver enable |
| rx_tick | input | 1 | Receiver bit-clock strobe, one cycle per bit |
| rx_break_det | input | 1 | Receiver has detected a break |
| rx_start_det | input | 1 | Receiver has detected a valid start bit |
| rxd_pin | input | 1 | Serial input pin |
| tx_core_sd | input | 1 | Transmitter core serial output |
| tx_rdy_raw | input | 1 | Transmitter ready flag from the core |
| tx_emp_raw | input | 1 | Transmitter empty flag from the core |
| txd_pin | output | 1 | Serial output pin |
| rx_core_sd | output | 1 | Serial data into the receiver core |
| tx_rdy_flag | output | 1 | Gated transmitter ready flag |
| tx_emp_flag | output | 1 | Gated transmitter empty flag |

## Verification
The routing results of R1, R3, R4, R5, R6 and R8 are combinational, so the bench drives inputs on a falling edge and compares one time unit later, inside the same cycle. The echoed bit of R2 is due on the cycle after the tick edge. The bench first holds rxd_pin steady for three cycles, which covers the two synchronizer stages. It then raises rx_tick for one cycle and compares after the next falling edge, and before the tick it confirms that txd_pin has not moved. The break hold of R7 and the release on a start bit each appear one edge after the strobe, and they are sampled the same way.

// File: rtl/uart_loop_pkg.sv
package uart_loop_pkg;
   typedef enum logic [1:0] {
      LM_NORMAL = 2'b00,
      LM_ECHO   = 2'b01,
      LM_LOCAL  = 2'b10,
      LM_REMOTE = 2'b11
   } loop_mode_e;

   localparam logic LINE_MARK  = 1'b1;
   localparam logic LINE_SPACE = 1'b0;
endpackage

// File: rtl/uart_loop_sync.sv
module uart_loop_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad
         $error("uart_loop_sync: STAGES must be 0..4");
      end
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= {STAGES{RST_VAL}};
            else if (STAGES == 1) sh_q <= din;
            else sh_q <= {sh_q[STAGES-2:0], din};
         end
         assign dout = sh_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/uart_loop_echo.sv
module uart_loop_echo (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic din,
   input  logic active,
   input  logic break_det,
   input  logic start_det,
   output logic echo_bit
);
   import uart_loop_pkg::*;

   logic bit_q;
   logic hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= LINE_MARK;
      else if (tick) bit_q <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q <= 1'b0;
      else if (!active || start_det) hold_q <= 1'b0;
      else if (break_det) hold_q <= 1'b1;
   end

   assign echo_bit = hold_q ? LINE_SPACE : bit_q;
endmodule

// File: rtl/uart_loop_mux.sv
module uart_loop_mux (
   input  uart_loop_pkg::loop_mode_e mode,
   input  logic rx_enable,
   input  logic rxd_pin,
   input  logic tx_core_sd,
   input  logic echo_bit,
   input  logic rdy_raw,
   input  logic emp_raw,
   output logic txd_pin,
   output logic rx_core_sd,
   output logic rdy_out,
   output logic emp_out
);
   import uart_loop_pkg::*;

   always_comb begin
      txd_pin    = tx_core_sd;
      rx_core_sd = rxd_pin;
      rdy_out    = rdy_raw;
      emp_out    = emp_raw;
      unique case (mode)
         LM_NORMAL: ;
         LM_ECHO: begin
            txd_pin = rx_enable ? echo_bit : LINE_MARK;
            rdy_out = 1'b0;
            emp_out = 1'b0;
         end
         LM_LOCAL: begin
            txd_pin    = LINE_MARK;
            rx_core_sd = tx_core_sd;
         end
         LM_REMOTE: begin
            txd_pin    = echo_bit;
            rx_core_sd = LINE_MARK;
            rdy_out    = 1'b0;
            emp_out    = 1'b0;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/uart_loop_router.sv
module uart_loop_router #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   input  logic       rx_enable,
   input  logic       rx_tick,
   input  logic       rx_break_det,
   input  logic       rx_start_det,
   input  logic       rxd_pin,
   input  logic       tx_core_sd,
   input  logic       tx_rdy_raw,
   input  logic       tx_emp_raw,
   output logic       txd_pin,
   output logic       rx_core_sd,
   output logic       tx_rdy_flag,
   output logic       tx_emp_flag
);
   import uart_loop_pkg::*;

   loop_mode_e mode_e;
   logic       rxd_sync;
   logic       echo_bit;
   logic       echo_active;

   assign mode_e      = loop_mode_e'(mode);
   assign echo_active = (mode_e == LM_ECHO) || (mode_e == LM_REMOTE);

   uart_loop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(LINE_MARK)) i_sync (
      .clk (clk), .rst_n (rst_n), .din (rxd_pin), .dout (rxd_sync)
   );

   uart_loop_echo i_echo (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (rx_tick),
      .din       (rxd_sync),
      .active    (echo_active),
      .break_det (rx_break_det),
      .start_det (rx_start_det),
      .echo_bit  (echo_bit)
   );

   uart_loop_mux i_mux (
      .mode       (mode_e),
      .rx_enable  (rx_enable),
      .rxd_pin    (rxd_pin),
      .tx_core_sd (tx_core_sd),
      .echo_bit   (echo_bit),
      .rdy_raw    (tx_rdy_raw),
      .emp_raw    (tx_emp_raw),
      .txd_pin    (txd_pin),
      .rx_core_sd (rx_core_sd),
      .rdy_out    (tx_rdy_flag),
      .emp_out    (tx_emp_flag)
   );
endmodule

// File: rtl/uart_loop_router_chk.sv
module uart_loop_router_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode,
   input logic       rx_enable,
   input logic       rx_tick,
   input logic       rx_break_det,
   input logic       rx_start_det,
   input logic       rxd_pin,
   input logic       tx_core_sd,
   input logic       tx_rdy_raw,
   input logic       tx_emp_raw,
   input logic       txd_pin,
   input logic       rx_core_sd,
   input logic       tx_rdy_flag,
   input logic       tx_emp_flag
);
   AST_NORMAL_TXD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |-> (txd_pin == tx_core_sd && rx_core_sd == rxd_pin)); // R1

   AST_ECHO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && rx_enable && !rx_tick && !rx_break_det && !rx_start_det)
      |=> (mode != 2'b01 || !rx_enable || $stable(txd_pin))); // R2

   AST_ECHO_RX_OFF_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && !rx_enable) |-> txd_pin); // R3

   AST_LOCAL_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10) |-> (txd_pin && rx_core_sd == tx_core_sd)); // R4

   AST_STATUS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[0] == 1'b1) |-> (!tx_rdy_flag && !tx_emp_flag)); // R5

   AST_REMOTE_RX_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b11) |-> rx_core_sd); // R6

   AST_BREAK_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && rx_enable && rx_break_det)
      |=> (mode != 2'b01 || !rx_enable || !txd_pin)); // R7
endmodule

bind uart_loop_router uart_loop_router_chk i_chk (.*);

// File: tb/test_uart_loop_router.sv
`timescale 1ns/1ps
module test_uart_loop_router;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'b00;
   logic       rx_enable = 1'b0;
   logic       rx_tick = 1'b0;
   logic       rx_break_det = 1'b0;
   logic       rx_start_det = 1'b0;
   logic       rxd_pin = 1'b1;
   logic       tx_core_sd = 1'b1;
   logic       tx_rdy_raw = 1'b0;
   logic       tx_emp_raw = 1'b0;
   logic       txd_pin, rx_core_sd, tx_rdy_flag, tx_emp_flag;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   uart_loop_router #(.SYNC_STAGES(2)) i_uart_loop_router (.*);

   // fields: mode[10:9] rxd[8] txsd[7] rxen[6] rdy[5] emp[4] | exp txd[3] rxsd[2] rdy[1] emp[0]
   localparam int NV = 9;
   localparam logic [10:0] VEC [NV] = '{
      {2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R1
      {2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}, // R1
      {2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 R9
      {2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R3
      {2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R4
      {2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}, // R4
      {2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R4 rxd ignored
      {2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R6
      {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}  // R6
   };

   task automatic check(input string req, input string what, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic echo_bit(input logic b);
      @(negedge clk) rxd_pin = b;
      repeat (3) @(negedge clk);
      rx_tick = 1'b1;
      @(negedge clk) rx_tick = 1'b0;
      #1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      mode = 2'b01; rx_enable = 1'b1; #1;
      check("R9", "txd after reset", txd_pin, 1'b1);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         {mode, rxd_pin, tx_core_sd, rx_enable, tx_rdy_raw, tx_emp_raw} = VEC[i][10:4];
         #1;
         check("R1/R3-R6", "txd", txd_pin, VEC[i][3]);
         check("R1/R3-R6", "rx_core_sd", rx_core_sd, VEC[i][2]);
         check("R5", "rdy", tx_rdy_flag, VEC[i][1]);
         check("R5", "emp", tx_emp_flag, VEC[i][0]);
      end

      // R2: echo bit by bit, held between ticks, tx_core_sd ignored
      @(negedge clk) mode = 2'b01; rx_enable = 1'b1; tx_core_sd = 1'b1;
      @(negedge clk) rxd_pin = 1'b0;
      repeat (3) @(negedge clk);
      #1 check("R2", "no change before tick", txd_pin, 1'b1);
      rx_tick = 1'b1;
      @(negedge clk) rx_tick = 1'b0;
      #1 check("R2", "echo 0", txd_pin, 1'b0);
      echo_bit(1'b1);
      check("R2", "echo 1", txd_pin, 1'b1);
      echo_bit(1'b0);
      check("R2", "echo 0 again", txd_pin, 1'b0);
      @(negedge clk) tx_core_sd = 1'b0; rxd_pin = 1'b1;
      repeat (2) @(negedge clk);
      #1 check("R2", "held, tx core ignored", txd_pin, 1'b0);

      // R3: receiver disabled -> mark; rx path still normal
      @(negedge clk) rx_enable = 1'b0; #1;
      check("R3", "rx off txd", txd_pin, 1'b1);
      check("R3", "rx path", rx_core_sd, 1'b1);

      // R6: remote shows echo register without rx_enable
      @(negedge clk) mode = 2'b11; #1;
      check("R6", "remote echo reg", txd_pin, 1'b0);

      // R8: immediate switch to normal mid-character
      @(negedge clk) mode = 2'b01; rx_enable = 1'b1; tx_core_sd = 1'b1; #1;
      check("R8", "echo before switch", txd_pin, 1'b0);
      #2 mode = 2'b00; #1;
      check("R8", "normal after switch", txd_pin, 1'b1);

      // R7: break hold and release on start bit
      @(negedge clk) mode = 2'b01; rxd_pin = 1'b1;
      echo_bit(1'b1);
      check("R7", "mark before break", txd_pin, 1'b1);
      @(negedge clk) rx_break_det = 1'b1;
      @(negedge clk) rx_break_det = 1'b0; #1;
      check("R7", "break space", txd_pin, 1'b0);
      echo_bit(1'b1);
      check("R7", "break held over tick", txd_pin, 1'b0);
      @(negedge clk) rx_start_det = 1'b1;
      @(negedge clk) rx_start_det = 1'b0; #1;
      check("R7", "released by start", txd_pin, 1'b1);

      // R7: leaving echo clears hold
      @(negedge clk) rx_break_det = 1'b1;
      @(negedge clk) rx_break_det = 1'b0; mode = 2'b00;
      @(negedge clk) mode = 2'b01; #1;
      check("R7", "hold cleared by mode exit", txd_pin, 1'b1);

      // R9: reset returns echo register to mark
      echo_bit(1'b0);
      check("R2", "echo 0 before reset", txd_pin, 1'b0);
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1; #1;
      check("R9", "mark after reset", txd_pin, 1'b1);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule